// File: doc/BRIEF.md
# Rectangle Fill and Copy Engine

This block carries out rectangle operations on a framebuffer held in a linear, byte-addressed pixel memory. The current pixel size (one to four bytes) and the screen width in pixels are plain control inputs. A fill paints a w×h area with a colour whose low bytes are repeated for every pixel. A copy moves a w×h area from a source corner to a destination corner. Its row order and byte order are chosen so that overlapping copies come out as if the data had passed through a temporary buffer.

Commands arrive on a valid/ready handshake. The engine accepts one command, runs it to completion through a single synchronous byte-wide memory port, and then raises a one-cycle completion pulse. The pulse carries the destination rectangle so that a deferred-redraw queue can record the damaged area. Back-pressure applies in one direction only. `cmd_ready` is high only while the engine is idle. A requester holds `cmd_valid` and its fields stable until it sees `cmd_ready` high at a clock edge. The completion pulse has no ready signal, and its consumer must take it in the cycle in which it appears.

Top module: `rect_engine`

## Requirements
- R1: The byte address of pixel (x,y) is bypp·x + (bypp·scr_width)·y, where `bypp` holds the pixel size in bytes as the plain value 1, 2, 3 or 4. One row of an operation covers bypp·w bytes. Consecutive rows are bypp·scr_width bytes apart.
- R2: A fill (`cmd_op`=0) uses the destination corner. Within each row, the byte at offset k receives colour byte (k mod bypp), where colour byte 0 is `cmd_colour[7:0]`.
- R3: A fill writes its top row with colour bytes in one write per cycle. It then fills each remaining row by reading the matching byte of the top row and writing it, so the port is busy for B + 2·B·(h−1) cycles, with B = bypp·w.
- R4: After a copy (`cmd_op`=1), the destination area holds the source area's bytes as they were before the command started, including when the two areas overlap. No byte outside the destination area changes.
- R5: A copy runs bottom-up, starting at the last row and stepping back one stride per row, when the destination row is below the source row (dst_y > src_y). Otherwise it runs top-down. Within a row, bytes are moved from the highest offset down when dst_x > src_x, and from offset 0 up otherwise.
- R6: A read is a cycle with `mem_req`=1 and `mem_we`=0, and its data is taken from `mem_rdata` in the next cycle. Every moved byte is a read followed at once by its write, so a copy makes B·h reads and takes 2·B·h port cycles.
- R7: A command is accepted on a clock edge where `cmd_valid` and `cmd_ready` are both high. `cmd_ready` stays low from that edge until the cycle after the completion pulse, so a command presented meanwhile waits.
- R8: `done_valid` is high for exactly one cycle, in the cycle after the last memory write. During that cycle `done_x`/`done_y`/`done_w`/`done_h` give the destination corner, width and height of the command.
- R9: A command with zero width or zero height makes no memory access and raises `done_valid` in the cycle after acceptance.
- R10: After reset, `cmd_ready` is high and `done_valid` and `mem_req` are low. No memory access occurs while the engine is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bypp | input | 3 | Bytes per pixel, 1 to 4 |
| scr_width | input | COORD_W | Screen width in pixels |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Engine idle, command will be taken |
| cmd_op | input | 1 | 0 = fill, 1 = copy |
| cmd_src_x | input | COORD_W | Copy source column |
| cmd_src_y | input | COORD_W | Copy source row |
| cmd_dst_x | input | COORD_W | Destination column |
| cmd_dst_y | input | COORD_W | Destination row |
| cmd_w | input | COORD_W | Width in pixels |
| cmd_h | input | COORD_W | Height in pixels |
| cmd_colour | input | 32 | Fill colour, low bypp bytes used |
| mem_req | output | 1 | Memory access this cycle |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | ADDR_W | Byte address |
| mem_wdata | output | 8 | Write data |
| mem_rdata | input | 8 | Read data, one cycle after the read |
| done_valid | output | 1 | One-cycle completion pulse |
| done_x | output | COORD_W | Damaged area column |
| done_y | output | COORD_W | Damaged area row |
| done_w | output | COORD_W | Damaged area width |
| done_h | output | COORD_W | Damaged area height |

## Verification
The completion pulse is due a fixed number of cycles after the accepting edge. For a fill it arrives B + 2·B·(h−1) + 1 cycles later, for a copy 2·B·h + 1 cycles later, and for an empty rectangle one cycle later. When the accepting edge occurs, the driver pushes the expected rectangle and the edge's cycle number into a scoreboard queue. A monitor samples on falling edges, pops the queue at each pulse, and compares both the rectangle and the elapsed cycle count. Once the engine is idle again, the bench compares the whole memory image with a reference model that applies fills directly and copies through a temporary buffer. It also compares the read and write counts with the counts each operation needs.

// File: rtl/rect_engine_pkg.sv
package rect_engine_pkg;
  typedef enum logic { OP_FILL = 1'b0, OP_COPY = 1'b1 } rect_op_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FILLROW,
    ST_READ,
    ST_WRITE,
    ST_DONE
  } walk_state_e;
endpackage

// File: rtl/rect_setup.sv
// Address arithmetic for a command at acceptance time (R1, R5).
module rect_setup
  import rect_engine_pkg::*;
#(
  parameter int ADDR_W  = 16,
  parameter int COORD_W = 10
) (
  input  logic [2:0]         bypp,
  input  logic [COORD_W-1:0] scr_width,
  input  logic               op,
  input  logic [COORD_W-1:0] sx,
  input  logic [COORD_W-1:0] sy,
  input  logic [COORD_W-1:0] dx,
  input  logic [COORD_W-1:0] dy,
  input  logic [COORD_W-1:0] w,
  input  logic [COORD_W-1:0] h,
  output logic [ADDR_W-1:0]  stride_o,
  output logic [ADDR_W-1:0]  row_bytes_o,
  output logic [ADDR_W-1:0]  src_first_o,
  output logic [ADDR_W-1:0]  dst_first_o,
  output logic               bottom_up_o,
  output logic               rev_bytes_o,
  output logic               empty_o
);
  logic               is_copy;
  logic [ADDR_W-1:0]  bpp_a;
  logic [COORD_W-1:0] sy_row, dy_row;

  assign is_copy     = (op == OP_COPY);
  assign bpp_a       = ADDR_W'(bypp);
  assign stride_o    = bpp_a * ADDR_W'(scr_width);
  assign row_bytes_o = bpp_a * ADDR_W'(w);
  assign bottom_up_o = is_copy && (dy > sy);
  assign rev_bytes_o = is_copy && (dx > sx);
  assign empty_o     = (w == '0) || (h == '0);

  // Bottom-up walks start on the last row of each area.
  assign sy_row = bottom_up_o ? (sy + h - COORD_W'(1)) : sy;
  assign dy_row = bottom_up_o ? (dy + h - COORD_W'(1)) : dy;

  assign src_first_o = bpp_a * ADDR_W'(sx) + stride_o * ADDR_W'(sy_row);
  assign dst_first_o = bpp_a * ADDR_W'(dx) + stride_o * ADDR_W'(dy_row);
endmodule

// File: rtl/rect_walker.sv
// Sequencer: top-row colour writes, then read/write byte moves row by row.
module rect_walker
  import rect_engine_pkg::*;
#(
  parameter int ADDR_W  = 16,
  parameter int COORD_W = 10
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic               is_copy,
  input  logic [2:0]         bypp,
  input  logic [31:0]        colour,
  input  logic [ADDR_W-1:0]  stride,
  input  logic [ADDR_W-1:0]  row_bytes,
  input  logic [ADDR_W-1:0]  src_first,
  input  logic [ADDR_W-1:0]  dst_first,
  input  logic               bottom_up,
  input  logic               rev_bytes,
  input  logic               empty,
  input  logic [COORD_W-1:0] rx,
  input  logic [COORD_W-1:0] ry,
  input  logic [COORD_W-1:0] rw,
  input  logic [COORD_W-1:0] rh,
  output logic               ready,
  output logic               mem_req,
  output logic               mem_we,
  output logic [ADDR_W-1:0]  mem_addr,
  output logic [7:0]         mem_wdata,
  input  logic [7:0]         mem_rdata,
  output logic               done_valid,
  output logic [COORD_W-1:0] done_x,
  output logic [COORD_W-1:0] done_y,
  output logic [COORD_W-1:0] done_w,
  output logic [COORD_W-1:0] done_h
);
  walk_state_e        state;
  logic [ADDR_W-1:0]  src_row, dst_row, stride_q, rowb_q, col;
  logic [COORD_W-1:0] rows_left;
  logic [1:0]         phase;
  logic [2:0]         bypp_q;
  logic [31:0]        colour_q;
  logic               fill_q, bottom_q, rev_q;

  logic               col_last, phase_last, row_last;
  logic [ADDR_W-1:0]  off, dst_next, src_next;

  assign col_last   = (col == rowb_q - ADDR_W'(1));
  assign row_last   = (rows_left == COORD_W'(1));
  assign phase_last = ({1'b0, phase} == bypp_q - 3'd1);
  assign off        = rev_q ? (rowb_q - ADDR_W'(1) - col) : col;
  assign dst_next   = bottom_q ? dst_row - stride_q : dst_row + stride_q;
  // A fill keeps reading its top row while the destination moves on.
  assign src_next   = fill_q ? src_row :
                      (bottom_q ? src_row - stride_q : src_row + stride_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      src_row   <= '0;
      dst_row   <= '0;
      stride_q  <= '0;
      rowb_q    <= '0;
      col       <= '0;
      rows_left <= '0;
      phase     <= '0;
      bypp_q    <= 3'd1;
      colour_q  <= '0;
      fill_q    <= 1'b0;
      bottom_q  <= 1'b0;
      rev_q     <= 1'b0;
      done_x    <= '0;
      done_y    <= '0;
      done_w    <= '0;
      done_h    <= '0;
    end else begin
      unique case (state)
        ST_IDLE: if (start) begin
          src_row   <= src_first;
          dst_row   <= dst_first;
          stride_q  <= stride;
          rowb_q    <= row_bytes;
          col       <= '0;
          rows_left <= rh;
          phase     <= '0;
          bypp_q    <= bypp;
          colour_q  <= colour;
          fill_q    <= !is_copy;
          bottom_q  <= bottom_up;
          rev_q     <= rev_bytes;
          done_x    <= rx;
          done_y    <= ry;
          done_w    <= rw;
          done_h    <= rh;
          if (empty)        state <= ST_DONE;
          else if (is_copy) state <= ST_READ;
          else              state <= ST_FILLROW;
        end
        ST_FILLROW: begin
          phase <= phase_last ? 2'd0 : phase + 2'd1;
          if (col_last) begin
            col <= '0;
            if (row_last) state <= ST_DONE;
            else begin
              rows_left <= rows_left - COORD_W'(1);
              src_row   <= dst_row;
              dst_row   <= dst_row + stride_q;
              state     <= ST_READ;
            end
          end else begin
            col <= col + ADDR_W'(1);
          end
        end
        ST_READ: state <= ST_WRITE;
        ST_WRITE: begin
          if (col_last) begin
            col <= '0;
            if (row_last) state <= ST_DONE;
            else begin
              rows_left <= rows_left - COORD_W'(1);
              dst_row   <= dst_next;
              src_row   <= src_next;
              state     <= ST_READ;
            end
          end else begin
            col   <= col + ADDR_W'(1);
            state <= ST_READ;
          end
        end
        ST_DONE: state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    mem_req   = 1'b0;
    mem_we    = 1'b0;
    mem_addr  = '0;
    mem_wdata = '0;
    unique case (state)
      ST_FILLROW: begin
        mem_req   = 1'b1;
        mem_we    = 1'b1;
        mem_addr  = dst_row + col;
        mem_wdata = colour_q[8*phase +: 8];
      end
      ST_READ: begin
        mem_req  = 1'b1;
        mem_addr = src_row + off;
      end
      ST_WRITE: begin
        mem_req   = 1'b1;
        mem_we    = 1'b1;
        mem_addr  = dst_row + off;
        mem_wdata = mem_rdata;
      end
      default: ;
    endcase
  end

  assign ready      = (state == ST_IDLE);
  assign done_valid = (state == ST_DONE);
endmodule

// File: rtl/rect_engine.sv
module rect_engine
  import rect_engine_pkg::*;
#(
  parameter int ADDR_W  = 16,
  parameter int COORD_W = 10
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [2:0]         bypp,
  input  logic [COORD_W-1:0] scr_width,
  input  logic               cmd_valid,
  output logic               cmd_ready,
  input  logic               cmd_op,
  input  logic [COORD_W-1:0] cmd_src_x,
  input  logic [COORD_W-1:0] cmd_src_y,
  input  logic [COORD_W-1:0] cmd_dst_x,
  input  logic [COORD_W-1:0] cmd_dst_y,
  input  logic [COORD_W-1:0] cmd_w,
  input  logic [COORD_W-1:0] cmd_h,
  input  logic [31:0]        cmd_colour,
  output logic               mem_req,
  output logic               mem_we,
  output logic [ADDR_W-1:0]  mem_addr,
  output logic [7:0]         mem_wdata,
  input  logic [7:0]         mem_rdata,
  output logic               done_valid,
  output logic [COORD_W-1:0] done_x,
  output logic [COORD_W-1:0] done_y,
  output logic [COORD_W-1:0] done_w,
  output logic [COORD_W-1:0] done_h
);
  logic [ADDR_W-1:0] stride, row_bytes, src_first, dst_first;
  logic              bottom_up, rev_bytes, empty, accept;

  assign accept = cmd_valid && cmd_ready;

  rect_setup #(.ADDR_W(ADDR_W), .COORD_W(COORD_W)) u_setup (
    .bypp(bypp), .scr_width(scr_width), .op(cmd_op),
    .sx(cmd_src_x), .sy(cmd_src_y), .dx(cmd_dst_x), .dy(cmd_dst_y),
    .w(cmd_w), .h(cmd_h),
    .stride_o(stride), .row_bytes_o(row_bytes),
    .src_first_o(src_first), .dst_first_o(dst_first),
    .bottom_up_o(bottom_up), .rev_bytes_o(rev_bytes), .empty_o(empty)
  );

  rect_walker #(.ADDR_W(ADDR_W), .COORD_W(COORD_W)) u_walker (
    .clk(clk), .rst_n(rst_n), .start(accept),
    .is_copy(cmd_op == OP_COPY), .bypp(bypp), .colour(cmd_colour),
    .stride(stride), .row_bytes(row_bytes),
    .src_first(src_first), .dst_first(dst_first),
    .bottom_up(bottom_up), .rev_bytes(rev_bytes), .empty(empty),
    .rx(cmd_dst_x), .ry(cmd_dst_y), .rw(cmd_w), .rh(cmd_h),
    .ready(cmd_ready),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .done_valid(done_valid), .done_x(done_x), .done_y(done_y),
    .done_w(done_w), .done_h(done_h)
  );
endmodule

// File: rtl/rect_engine_chk.sv
module rect_engine_chk #(
  parameter int COORD_W = 10
) (
  input logic               clk,
  input logic               rst_n,
  input logic               cmd_valid,
  input logic               cmd_ready,
  input logic [COORD_W-1:0] cmd_w,
  input logic [COORD_W-1:0] cmd_h,
  input logic               mem_req,
  input logic               mem_we,
  input logic               done_valid
);
  a_r7_accept_busy: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd_ready |=> !cmd_ready);

  a_r7_hold_busy: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_ready && !done_valid |=> !cmd_ready);

  a_r8_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done_valid |=> !done_valid && cmd_ready);

  a_r8_done_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    done_valid |-> !mem_req);

  a_r9_zero_done: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd_ready && (cmd_w == '0 || cmd_h == '0) |=> done_valid);

  a_r10_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_ready |-> !mem_req);

  a_r6_read_then_write: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_we |=> mem_req && mem_we);
endmodule

bind rect_engine rect_engine_chk #(.COORD_W(COORD_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
  .cmd_w(cmd_w), .cmd_h(cmd_h), .mem_req(mem_req), .mem_we(mem_we),
  .done_valid(done_valid)
);

// File: tb/tb_rect_engine.sv
`timescale 1ns/1ps
module tb_rect_engine;
  localparam int AW = 16;
  localparam int CW = 10;
  localparam int SCRW = 32;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic          rst_n;
  logic [2:0]    bypp;
  logic [CW-1:0] scr_width;
  logic          cmd_valid, cmd_ready, cmd_op;
  logic [CW-1:0] cmd_src_x, cmd_src_y, cmd_dst_x, cmd_dst_y, cmd_w, cmd_h;
  logic [31:0]   cmd_colour;
  logic          mem_req, mem_we;
  logic [AW-1:0] mem_addr;
  logic [7:0]    mem_wdata, mem_rdata;
  logic          done_valid;
  logic [CW-1:0] done_x, done_y, done_w, done_h;

  rect_engine #(.ADDR_W(AW), .COORD_W(CW)) dut (.*);

  logic [7:0] mem [4096];
  logic [7:0] model [4096];
  int rd_cnt = 0, wr_cnt = 0, cyc = 0;
  int checks = 0, fails = 0;

  typedef struct { int x, y, w, h, lat, acc; } exp_t;
  exp_t q[$];

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (mem_req) begin
      if (mem_we) begin mem[mem_addr[11:0]] <= mem_wdata; wr_cnt <= wr_cnt + 1; end
      else begin mem_rdata <= mem[mem_addr[11:0]]; rd_cnt <= rd_cnt + 1; end
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Scoreboard monitor: rectangle and latency of every completion pulse (R8, R3, R9).
  always @(negedge clk) begin
    if (rst_n && done_valid) begin
      if (q.size() == 0) chk(0, "R8", "unexpected done pulse", 1, 0);
      else begin
        exp_t e;
        e = q.pop_front();
        chk(done_x == e.x && done_y == e.y && done_w == e.w && done_h == e.h,
            "R8", "done rectangle x/y/w/h packed",
            {done_x, done_y, done_w, done_h},
            {CW'(e.x), CW'(e.y), CW'(e.w), CW'(e.h)});
        chk(cyc - e.acc == e.lat, "R3_R9", "cycles from accept to done",
            cyc - e.acc, e.lat);
      end
    end
  end

  always @(posedge clk) begin
    if (cyc > 150000) begin
      fails++;
      $display("FAIL watchdog: actual %0d cycles expected below 150000", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  function automatic int addr_of(int bp, int x, int y);
    return bp * x + bp * SCRW * y;  // R1
  endfunction

  task automatic model_apply(input bit op, input int bp, input int sx, input int sy,
                             input int dx, input int dy, input int w, input int h,
                             input logic [31:0] c);
    logic [7:0] tmp [4096];
    if (!op) begin
      for (int r = 0; r < h; r++)
        for (int k = 0; k < bp * w; k++)
          model[addr_of(bp, dx, dy + r) + k] = c[8*(k % bp) +: 8];
    end else begin
      for (int r = 0; r < h; r++)
        for (int k = 0; k < bp * w; k++)
          tmp[r * bp * w + k] = model[addr_of(bp, sx, sy + r) + k];
      for (int r = 0; r < h; r++)
        for (int k = 0; k < bp * w; k++)
          model[addr_of(bp, dx, dy + r) + k] = tmp[r * bp * w + k];
    end
  endtask

  // Driver: push expectation at the accepting edge; optionally wait and compare memory.
  task automatic issue(input string req, input bit op, input int bp,
                       input int sx, input int sy, input int dx, input int dy,
                       input int w, input int h, input logic [31:0] c, input bit wait_done);
    exp_t e;
    int b, n, rd0, wr0, bad, first;
    b = bp * w;
    if (w == 0 || h == 0) n = 0;
    else if (op) n = 2 * b * h;
    else n = b + 2 * b * (h - 1);
    e.x = dx; e.y = dy; e.w = w; e.h = h; e.lat = n + 1;
    model_apply(op, bp, sx, sy, dx, dy, w, h, c);
    @(negedge clk);
    bypp = 3'(bp); cmd_op = op; cmd_colour = c;
    cmd_src_x = CW'(sx); cmd_src_y = CW'(sy); cmd_dst_x = CW'(dx); cmd_dst_y = CW'(dy);
    cmd_w = CW'(w); cmd_h = CW'(h); cmd_valid = 1'b1;
    while (!cmd_ready) @(negedge clk);
    @(posedge clk);
    rd0 = rd_cnt; wr0 = wr_cnt;
    e.acc = cyc;
    q.push_back(e);
    @(negedge clk);
    cmd_valid = 1'b0;
    if (wait_done) begin
      while (!cmd_ready) @(negedge clk);
      bad = 0; first = -1;
      for (int i = 0; i < 4096; i++)
        if (mem[i] !== model[i]) begin bad++; if (first < 0) first = i; end
      chk(bad == 0, req, "memory bytes differing from model (first index in next line)",
          bad, 0);
      if (bad != 0) $display("  first bad index %0d", first);
      chk(rd_cnt - rd0 == (op ? b * h : (h == 0 ? 0 : b * (h - 1))), "R6",
          "read count", rd_cnt - rd0, op ? b * h : (h == 0 ? 0 : b * (h - 1)));
      chk(wr_cnt - wr0 == b * h, "R2_R4", "write count", wr_cnt - wr0, b * h);
    end
  endtask

  initial begin
    rst_n = 1'b0; bypp = 3'd1; scr_width = CW'(SCRW); cmd_valid = 1'b0; cmd_op = 1'b0;
    cmd_src_x = '0; cmd_src_y = '0; cmd_dst_x = '0; cmd_dst_y = '0;
    cmd_w = '0; cmd_h = '0; cmd_colour = '0; mem_rdata = '0;
    for (int i = 0; i < 4096; i++) begin
      mem[i] = 8'((i * 7 + 3) ^ (i >> 5));
      model[i] = mem[i];
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(cmd_ready == 1'b1, "R10", "cmd_ready after reset", cmd_ready, 1);
    chk(done_valid == 1'b0, "R10", "done_valid after reset", done_valid, 0);
    chk(mem_req == 1'b0, "R10", "mem_req after reset", mem_req, 0);

    issue("R2", 0, 4, 0, 0, 2, 3, 3, 2, 32'hAABBCCDD, 1);
    issue("R1_R2", 0, 3, 0, 0, 5, 1, 4, 3, 32'h00112233, 1);
    issue("R3", 0, 1, 0, 0, 0, 0, 1, 1, 32'h000000E7, 1);
    issue("R1", 0, 2, 0, 0, 30, 10, 2, 4, 32'h0000BEEF, 1);
    issue("R4", 1, 2, 1, 2, 10, 5, 4, 3, 32'h0, 1);
    issue("R5 bottom-up", 1, 1, 4, 4, 5, 6, 6, 5, 32'h0, 1);
    issue("R5 top-down", 1, 1, 4, 8, 3, 5, 6, 5, 32'h0, 1);
    issue("R5 bytes descending", 1, 4, 2, 20, 4, 20, 5, 2, 32'h0, 1);
    issue("R5 bytes ascending", 1, 4, 6, 20, 3, 20, 5, 2, 32'h0, 1);
    issue("R9 zero width", 0, 2, 0, 0, 4, 4, 0, 3, 32'h12345678, 1);
    issue("R9 zero height", 1, 1, 0, 0, 8, 8, 5, 0, 32'h0, 1);

    // R7: second command held off while the first runs.
    issue("R7", 1, 1, 0, 12, 2, 14, 8, 3, 32'h0, 0);
    @(negedge clk);
    cmd_valid = 1'b1;
    chk(cmd_ready == 1'b0, "R7", "cmd_ready while busy", cmd_ready, 0);
    issue("R7", 0, 2, 0, 0, 1, 26, 6, 2, 32'h0000A55A, 1);

    repeat (5) @(negedge clk);
    chk(q.size() == 0, "R8", "pending scoreboard entries", q.size(), 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule